// File: doc/BRIEF.md
# Four-Channel Stepped-Duty PWM Generator

This block drives four motor-speed outputs with pulse-width modulation. Each channel takes a 3-bit speed code, and the code selects one of eight fixed duty cycles. The duties do not scale linearly with the code: codes 0 through 6 step upward by 15 percentage points each, from 0% to 90%. Code 7 jumps to a full 100%, so the output never drops low.

All channels share one period sequencer. This is a counter that advances on a clock-enable `tick` and runs through `PERIOD` slots, which is 100 slots by default. Each channel holds a compare value. It latches that value from its code only on the tick that wraps the sequencer back to slot 0. A code change in the middle of a period is therefore held back until the next period begins, and no shortened pulse can appear. During a slot, a channel output is high exactly when the slot number is below that channel's compare value.

The sequencer has three named states:
- `SQ_START`: slot 0.
- `SQ_RUN`: the interior slots.
- `SQ_LAST`: slot `PERIOD-1`.

Its transitions are:
- `advance`: `SQ_START`/`SQ_RUN` to `SQ_RUN`.
- `reach_end`: to `SQ_LAST` when the next slot is the final one.
- `wrap`: `SQ_LAST` to `SQ_START`. This is the only transition that loads new compare values.

Each channel has two states, `CH_LOW` and `CH_HIGH`. Its transitions are:
- `rise`: LOW to HIGH when the new slot is below the compare value.
- `fall`: HIGH to LOW when the new slot is not below the compare value.
- `hold`: no change, either when there is no tick or when the level is unchanged.

Top module: `stepped_pwm_quad`

## Requirements
- R1: While synchronous reset `rst` is high, every output is low on the following clock, the sequencer returns to slot 0 and every channel's compare value becomes 0. After release, no output goes high until a code latched at a wrap says so.
- R2: The sequencer advances one slot per clock with `tick`=1 and counts slots 0 to `PERIOD-1` (0..99). From the last slot it wraps to 0.
- R3: Code 0 keeps the channel output low for every slot of the period.
- R4: Codes 1 to 6 keep the output high for the first 15, 30, 45, 60, 75 or 90 slots of the period respectively, then low for the rest.
- R5: Code 7 keeps the output high for all 100 slots. Across consecutive periods at code 7 there is no low slot.
- R6: A code change that arrives after the wrap tick has no effect on the output until the next wrap. The code present at the wrap tick is the one used, including a change made in that very cycle.
- R7: The four channels are independent. Channel i takes its code from `level_in[3*i+2:3*i]` and drives `pwm_out[i]`.
- R8: In every slot, output i is high exactly when the slot number is below channel i's latched compare value. The output rises at the start of the period when the compare value is nonzero.
- R9: While `tick` is 0, the sequencer and all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Clock enable. Advances the period sequencer by one slot. |
| level_in | input | 12 | Four 3-bit speed codes, with channel i in bits 3*i+2..3*i |
| pwm_out | output | 4 | PWM outputs, one per channel |

## Verification
Two functions can fall in the same cycle: the latch of a new code at the wrap tick, and the output transition that code causes in slot 0. Driving code 7 then code 0 means the new code must pull the output low on exactly the edge that wraps. The bench provokes this by changing codes on the clock just before the wrap, and also halfway through a period. A behavioural slot-and-compare model is compared with every output on every cycle. Per-period high-slot counts are checked against the duty table, and the bench checks that outputs do not move while `tick` is held low.

// File: rtl/stpwm_pkg.sv
package stpwm_pkg;

    localparam int unsigned LVL_W = 3;

    typedef logic [LVL_W-1:0] level_t;

    // period sequencer states
    typedef enum logic [1:0] {
        SQ_START = 2'd0,
        SQ_RUN   = 2'd1,
        SQ_LAST  = 2'd2
    } seq_state_t;

    // per-channel output states
    typedef enum logic {
        CH_LOW  = 1'b0,
        CH_HIGH = 1'b1
    } ch_state_t;

    // slots of high time for a code; top code saturates to the full period
    function automatic int unsigned duty_slots(level_t lv, int unsigned period,
                                               int unsigned step);
        int unsigned raw;
        if (lv == '1) begin
            return period;
        end
        raw = int'(lv) * step;
        return (raw > period) ? period : raw;
    endfunction

endpackage

// File: rtl/stpwm_period.sv
module stpwm_period
    import stpwm_pkg::*;
#(
    parameter int unsigned PERIOD = 100,
    localparam int unsigned CW     = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nxt,
    output logic          wrap
);

    localparam logic [CW-1:0] LAST_C = CW'(PERIOD - 1);

    seq_state_t    seq_q;
    seq_state_t    seq_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] step_c;

    assign step_c = cnt_q + 1'b1;

    // next-state process
    always_comb begin
        seq_d   = seq_q;
        cnt_nxt = cnt_q;
        wrap    = 1'b0;
        if (tick) begin
            unique case (seq_q)
                SQ_START, SQ_RUN: begin
                    cnt_nxt = step_c;
                    seq_d   = (step_c == LAST_C) ? SQ_LAST : SQ_RUN;
                end
                SQ_LAST: begin
                    cnt_nxt = '0;
                    seq_d   = SQ_START;
                    wrap    = 1'b1;
                end
                default: begin
                    cnt_nxt = '0;
                    seq_d   = SQ_START;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= SQ_START;
            cnt_q <= '0;
        end else begin
            seq_q <= seq_d;
            cnt_q <= cnt_nxt;
        end
    end

    assign cnt = cnt_q;

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_C);

    assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q == LAST_C) |=> (cnt_q == '0));

    assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));

endmodule

// File: rtl/stpwm_chan.sv
module stpwm_chan
    import stpwm_pkg::*;
#(
    parameter int unsigned PERIOD = 100,
    parameter int unsigned STEP   = 15,
    localparam int unsigned CW     = $clog2(PERIOD),
    localparam int unsigned CMPW   = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          wrap,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cnt_nxt,
    input  level_t        level,
    output logic          out
);

    localparam logic [CMPW-1:0] FULL_C = CMPW'(PERIOD);

    ch_state_t       st_q;
    ch_state_t       st_d;
    logic [CMPW-1:0] cmp_q;
    logic [CMPW-1:0] cmp_d;
    logic            below;

    // compare value is only replaced on the wrap tick
    always_comb begin
        cmp_d = wrap ? CMPW'(duty_slots(level, PERIOD, STEP)) : cmp_q;
        below = (CMPW'(cnt_nxt) < cmp_d);
    end

    // transitions: rise, fall, hold
    always_comb begin
        st_d = st_q;
        if (tick) begin
            unique case (st_q)
                CH_LOW:  st_d = below ? CH_HIGH : CH_LOW;
                CH_HIGH: st_d = below ? CH_HIGH : CH_LOW;
                default: st_d = CH_LOW;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= CH_LOW;
            cmp_q <= '0;
        end else begin
            st_q  <= st_d;
            cmp_q <= cmp_d;
        end
    end

    // output process
    always_comb begin
        out = (st_q == CH_HIGH);
    end

    assert_zero_low_R3: assert property (@(posedge clk) disable iff (rst)
        (cmp_q == '0) |-> !out);

    assert_full_high_R5: assert property (@(posedge clk) disable iff (rst)
        (cmp_q == FULL_C) |-> out);

    assert_cmp_only_at_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(cmp_q));

    assert_slot_compare_R8: assert property (@(posedge clk) disable iff (rst)
        out == (CMPW'(cnt) < cmp_q));

    assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(out));

endmodule

// File: rtl/stepped_pwm_quad.sv
module stepped_pwm_quad
    import stpwm_pkg::*;
#(
    parameter int unsigned NCH    = 4,
    parameter int unsigned PERIOD = 100,
    parameter int unsigned STEP   = 15,
    localparam int unsigned CW     = $clog2(PERIOD)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [NCH*LVL_W-1:0] level_in,
    output logic [NCH-1:0]       pwm_out
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;
    logic          wrap;

    stpwm_period #(.PERIOD(PERIOD)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .cnt     (cnt),
        .cnt_nxt (cnt_nxt),
        .wrap    (wrap)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        stpwm_chan #(.PERIOD(PERIOD), .STEP(STEP)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .wrap    (wrap),
            .cnt     (cnt),
            .cnt_nxt (cnt_nxt),
            .level   (level_in[g*LVL_W +: LVL_W]),
            .out     (pwm_out[g])
        );
    end

    assert_reset_low_R1: assert property (@(posedge clk)
        $past(rst) |-> (pwm_out == '0));

endmodule

// File: tb/stepped_pwm_quad_test.sv
module stepped_pwm_quad_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [11:0] level_in = '0;
    logic [3:0]  pwm_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int m_cnt = 0;
    int m_cmp [4] = '{0, 0, 0, 0};

    stepped_pwm_quad uut (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .level_in (level_in),
        .pwm_out  (pwm_out)
    );

    always #4 clk = ~clk;

    function automatic int ref_duty(input int code);
        case (code)
            0: return 0;
            1: return 15;
            2: return 30;
            3: return 45;
            4: return 60;
            5: return 75;
            6: return 90;
            default: return 100;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: slot counter and latched compares
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0;
            for (int i = 0; i < 4; i++) m_cmp[i] = 0;
        end else if (tick) begin
            if (m_cnt == 99) begin
                m_cnt = 0;
                for (int i = 0; i < 4; i++) m_cmp[i] = ref_duty(int'(level_in[i*3 +: 3]));
            end else begin
                m_cnt++;
            end
        end
    end

    // per-cycle comparison (R8, R2)
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int i = 0; i < 4; i++) begin
                chk(pwm_out[i] == (m_cnt < m_cmp[i]), "R8 per-slot output",
                    int'(pwm_out[i]), int'(m_cnt < m_cmp[i]));
            end
        end
    end

    task automatic wait_last;
        do @(negedge clk); while (m_cnt != 99);
    endtask

    // set codes on the clock before the wrap, then count high slots over one period
    task automatic run_period(input logic [11:0] lv, input int mid,
                              input logic [11:0] alt, input string tag);
        int hi [4];
        wait_last();
        level_in = lv;
        for (int i = 0; i < 4; i++) hi[i] = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) hi[i] += int'(pwm_out[i]);
            if (k == mid) level_in = alt;
        end
        for (int i = 0; i < 4; i++)
            chk(hi[i] == ref_duty(int'(lv[i*3 +: 3])), tag, hi[i], ref_duty(int'(lv[i*3 +: 3])));
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog R2 actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [3:0] snap;
        level_in = 12'o7777;
        repeat (3) @(negedge clk);
        chk(pwm_out == 4'b0000, "R1 outputs low in reset", int'(pwm_out), 0);
        rst = 1'b0;
        tick = 1'b1;
        // R1: code 0 loaded by reset, so the first period stays low despite code 7
        for (int k = 0; k < 98; k++) begin
            @(negedge clk);
            if (pwm_out != 4'b0000) begin
                chk(1'b0, "R1 first period low", int'(pwm_out), 0);
                break;
            end
        end
        chk(pwm_out == 4'b0000, "R1 first period low", int'(pwm_out), 0);

        // R3, R4, R7: distinct codes per channel (ch0=0, ch1=1, ch2=2, ch3=3)
        run_period({3'd3, 3'd2, 3'd1, 3'd0}, 200, '0, "R3/R4/R7 codes 0-3");
        // R4, R5: ch0=4, ch1=5, ch2=6, ch3=7
        run_period({3'd7, 3'd6, 3'd5, 3'd4}, 200, '0, "R4/R5 codes 4-7");
        // R5: full high across consecutive periods
        run_period(12'o7777, 200, '0, "R5 code 7 period A");
        chk(pwm_out == 4'b1111, "R5 no low slot at boundary", int'(pwm_out), 15);
        run_period(12'o7777, 200, '0, "R5 code 7 period B");
        // R6: change halfway through the period is ignored
        run_period(12'o7777, 50, 12'o0000, "R6 mid-period change ignored");
        // same cycle: code 7 to 0 at the wrap tick pulls low in slot 0
        run_period(12'o0000, 200, '0, "R6 change at wrap takes effect");
        run_period({3'd6, 3'd1, 3'd4, 3'd2}, 30, {3'd0, 3'd7, 3'd0, 3'd7}, "R6/R7 mixed mid change");
        run_period({3'd0, 3'd7, 3'd0, 3'd7}, 200, '0, "R7 alternate channels");

        // R9: tick held low mid-period
        wait_last();
        level_in = {3'd1, 3'd3, 3'd5, 3'd7};
        repeat (40) @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
        snap = pwm_out;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            chk(pwm_out == snap, "R9 outputs hold without tick", int'(pwm_out), int'(snap));
        end
        tick = 1'b1;
        // R2: period resumes; slot count checked via the next measured period
        run_period({3'd2, 3'd4, 3'd6, 3'd3}, 200, '0, "R2/R4 after tick pause");

        // R1: reset mid-run clears outputs
        level_in = 12'o7777;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(pwm_out == 4'b0000, "R1 mid-run reset", int'(pwm_out), 0);
        rst = 1'b0;
        run_period(12'o5555, 200, '0, "R1/R4 after second reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule